// File: doc/BRIEF.md
# Cascaded 32-bit Free-Running Time Base

This block builds a 32-bit free-running time base out of two 16-bit up-counters. The low channel counts ticks of a prescaled master clock and wraps through its whole 16-bit range. On the way it drives a square wave with a 50% duty cycle. The high channel does not take a carry from the low channel. It samples that wave into the master clock domain and counts its rising edges, so it advances once for every 65536 low counts.

Both counters, the prescaler and the wave are cleared together by a block-level synchronous command. Each channel has its own clock enable. Both halves come out on their own ports and joined as one 32-bit word. The high half lags the low wrap by a few clocks, so a single read of the joined word can be torn. A small reader FSM takes a consistent sample instead. It reads high, then low, then high again, and repeats until both high reads agree. Only then does it raise valid with the 32-bit result.

Top module: `ctb_timebase`

## Requirements
- R1: While lo_en is high, the low count advances by one every PRESC_DIV master clocks. After a sync command its first step comes PRESC_DIV edges later. It wraps from 0xFFFF to 0x0000 and is not cleared when it reaches 0x8000.
- R2: While lo_en is low, the low count and the prescaler phase hold their values.
- R3: lo_wave is 1 after reset or sync. It goes to 0 on the edge after the low count first equals 0x8000. It goes back to 1 on the edge after the low count first equals 0x0000.
- R4: The high count increases by one on the fourth master clock edge after the edge on which the low count wraps to 0x0000.
- R5: If hi_en is low on the edge where the high count would step, that step is lost and the high count holds.
- R6: A sync_cmd sampled high clears the low count, high count and prescaler and sets lo_wave to 1 on that edge. This takes priority over both enables.
- R7: combined always equals hi_count in bits 31:16 and lo_count in bits 15:0, in the same cycle.
- R8: Suppose rd_req is high on an edge E0 while the reader is idle. The reader then takes the high count at E0+1 and the low count at E0+2, and compares the high count at E0+3. If the two high values match, snap_valid is high for exactly one cycle after E0+3, and snap_value holds {high, low}. snap_value keeps that value until the next valid.
- R9: On a mismatch, the second high read becomes the new first read. The low count is read again on the next edge and the compare follows one edge after that. snap_valid is raised only after a matching pair.
- R10: rd_req is ignored while a sample is in progress.
- R11: During reset both counts and combined are 0, lo_wave is 1 and snap_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_cmd | input | 1 | Block-level synchronous clear of both channels |
| lo_en | input | 1 | Clock enable of the low channel and its prescaler |
| hi_en | input | 1 | Clock enable of the high channel |
| rd_req | input | 1 | Starts one consistent 32-bit sample |
| lo_count | output | HALF_W | Low channel count |
| hi_count | output | HALF_W | High channel count |
| combined | output | 2*HALF_W | {hi_count, lo_count} |
| lo_wave | output | 1 | Low channel compare waveform |
| snap_valid | output | 1 | One-cycle pulse: snap_value is consistent |
| snap_value | output | 2*HALF_W | Last consistent 32-bit sample |

## Verification
The high-half step and the reader's compare window can land in the same few cycles. When that happens, the high count changes between the first and second high reads. The bench provokes this by raising rd_req exactly two low counts after a wrap, with a prescale of one. The high step then falls between the two high reads. Correct behaviour is judged in three ways: snap_valid stays low on the cycle where a single pass would have finished, it rises two cycles later, and the value it carries is the post-step word rather than the torn one.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  typedef enum logic [1:0] {
    SN_IDLE,
    SN_HI1,
    SN_LO,
    SN_HI2
  } snap_st_e;

  // next level of the compare waveform: the clear match wins over the set match
  function automatic logic wave_next(input logic cur, input logic at_set, input logic at_clr);
    if (at_clr) return 1'b0;
    if (at_set) return 1'b1;
    return cur;
  endfunction

  // rising edge seen across a synchronizer output pair
  function automatic logic rise_seen(input logic newer, input logic older);
    return newer & ~older;
  endfunction

endpackage

// File: rtl/ctb_lo_chan.sv
module ctb_lo_chan #(
  parameter int W         = 16,
  parameter int DIV       = 8,
  parameter int SET_MATCH = 0,
  parameter int CLR_MATCH = 32768
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         wave
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] SET_V = W'(SET_MATCH);
  localparam logic [W-1:0] CLR_V = W'(CLR_MATCH);

  logic tick;

  generate
    if (DIV == 1) begin : g_nodiv
      assign tick = en;
    end else begin : g_div
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre <= '0;
        else if (clr)    pre <= '0;
        else if (en)     pre <= (pre == PW'(DIV - 1)) ? '0 : pre + 1'b1;
      end
      assign tick = en && (pre == PW'(DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wave <= 1'b1;
    else if (clr) wave <= 1'b1;
    else          wave <= ctb_pkg::wave_next(wave, cnt == SET_V, cnt == CLR_V);
  end

  // R1: a tick advances the count by exactly one, wrapping included
  a_r1_lo_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> cnt == $past(cnt) + 1'b1);
  // R2: no tick, no change
  a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
  // R3: wave low after the clear match
  a_r3_wave_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CLR_V && !clr) |=> !wave);

endmodule

// File: rtl/ctb_hi_chan.sv
module ctb_hi_chan #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         wave_in,
  output logic [W-1:0] cnt
);
  logic [STAGES:0] chain;
  logic            step;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain[i] <= 1'b1;
        else if (clr) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= wave_in;
        else          chain[i] <= chain[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign step = ctb_pkg::rise_seen(chain[STAGES-1], chain[STAGES]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (step && en) cnt <= cnt + 1'b1;
  end

  // R4: the high count moves only on a detected edge
  a_r4_hi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(cnt));
  a_r4_hi_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step && en) |=> cnt == $past(cnt) + 1'b1);
  // R5: a disabled channel drops the step
  a_r5_hi_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(cnt));
  // R4: edge detect never fires twice in a row
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

endmodule

// File: rtl/ctb_snap.sv
module ctb_snap #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_req,
  input  logic [W-1:0]   hi_in,
  input  logic [W-1:0]   lo_in,
  output logic           valid,
  output logic [2*W-1:0] value
);
  import ctb_pkg::*;

  snap_st_e     st;
  logic [W-1:0] hi_first;
  logic [W-1:0] lo_seen;
  logic         retry;
  logic         match;

  assign match = (hi_in == hi_first);
  assign retry = (st == SN_HI2) && !match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SN_IDLE;
      hi_first <= '0;
      lo_seen  <= '0;
      valid    <= 1'b0;
      value    <= '0;
    end else begin
      valid <= 1'b0;
      unique case (st)
        SN_IDLE: if (rd_req) st <= SN_HI1;
        SN_HI1: begin
          hi_first <= hi_in;
          st       <= SN_LO;
        end
        SN_LO: begin
          lo_seen <= lo_in;
          st      <= SN_HI2;
        end
        SN_HI2: begin
          if (match) begin
            value <= {hi_first, lo_seen};
            valid <= 1'b1;
            st    <= SN_IDLE;
          end else begin
            hi_first <= hi_in;
            st       <= SN_LO;
          end
        end
        default: st <= SN_IDLE;
      endcase
    end
  end

  // R8: valid is a single-cycle pulse
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R9: a mismatch goes back to the low read without raising valid
  a_r9_retry: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> (!valid && st == SN_LO));
  // R8: value only changes together with valid
  a_r8_value_held: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(value) || $past(st) == SN_HI2);
  // R10: a request during a sample does not restart it
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SN_HI1) |=> st == SN_LO);

endmodule

// File: rtl/ctb_timebase.sv
module ctb_timebase #(
  parameter int HALF_W     = 16,
  parameter int PRESC_DIV  = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_cmd,
  input  logic                lo_en,
  input  logic                hi_en,
  input  logic                rd_req,
  output logic [HALF_W-1:0]   lo_count,
  output logic [HALF_W-1:0]   hi_count,
  output logic [2*HALF_W-1:0] combined,
  output logic                lo_wave,
  output logic                snap_valid,
  output logic [2*HALF_W-1:0] snap_value
);
  localparam int SET_AT = 0;
  localparam int CLR_AT = 1 << (HALF_W - 1);

  ctb_lo_chan #(
    .W(HALF_W), .DIV(PRESC_DIV), .SET_MATCH(SET_AT), .CLR_MATCH(CLR_AT)
  ) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(sync_cmd), .en(lo_en),
    .cnt(lo_count), .wave(lo_wave)
  );

  ctb_hi_chan #(.W(HALF_W), .STAGES(SYNC_STAGE)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(sync_cmd), .en(hi_en),
    .wave_in(lo_wave), .cnt(hi_count)
  );

  ctb_snap #(.W(HALF_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
    .hi_in(hi_count), .lo_in(lo_count),
    .valid(snap_valid), .value(snap_value)
  );

  assign combined = {hi_count, lo_count};

  // R6: sync clears both halves and restores the wave
  a_r6_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sync_cmd |=> (lo_count == '0 && hi_count == '0 && lo_wave));
  // R7: both halves of the joined word track their ports
  a_r7_join: assert property (@(posedge clk) disable iff (!rst_n)
    combined[HALF_W-1:0] == lo_count && combined[2*HALF_W-1:HALF_W] == hi_count);

endmodule

// File: tb/test_ctb_timebase.sv
`timescale 1ns/1ps
module test_ctb_timebase;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_cmd = 1'b0, lo_en = 1'b0, hi_en = 1'b1, rd_req = 1'b0;
  logic [15:0] lo_count, hi_count, d_lo, d_hi;
  logic [31:0] combined, snap_value, d_comb, d_snap;
  logic lo_wave, snap_valid, d_wave, d_valid;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ctb_timebase #(.HALF_W(16), .PRESC_DIV(1)) i_ctb_timebase (
    .clk(clk), .rst_n(rst_n), .sync_cmd(sync_cmd), .lo_en(lo_en), .hi_en(hi_en),
    .rd_req(rd_req), .lo_count(lo_count), .hi_count(hi_count), .combined(combined),
    .lo_wave(lo_wave), .snap_valid(snap_valid), .snap_value(snap_value));

  ctb_timebase #(.HALF_W(16), .PRESC_DIV(4)) i_ctb_timebase_div (
    .clk(clk), .rst_n(rst_n), .sync_cmd(sync_cmd), .lo_en(lo_en), .hi_en(hi_en),
    .rd_req(1'b0), .lo_count(d_lo), .hi_count(d_hi), .combined(d_comb),
    .lo_wave(d_wave), .snap_valid(d_valid), .snap_value(d_snap));

  // {lo_en, edges}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 16'd100}, {1'b0, 16'd37}, {1'b1, 16'd1},
    {1'b0, 16'd5},   {1'b1, 16'd258}, {1'b1, 16'd3}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int exp_lo;
    int en_edges;
    int pulses;
    tick(3);
    chk("R11 lo", {16'h0, lo_count}, 0);
    chk("R11 hi", {16'h0, hi_count}, 0);
    chk("R11 comb", combined, 0);
    chk("R11 wave", {31'h0, lo_wave}, 1);
    chk("R11 valid", {31'h0, snap_valid}, 0);
    rst_n = 1'b1;
    sync_cmd = 1'b1; tick(1); sync_cmd = 1'b0;

    // table walk: R1 stepping, R2 holding, R7 joining, prescale of 4 on the second copy
    exp_lo = 0;
    en_edges = 0;
    foreach (VEC[k]) begin
      lo_en = VEC[k][16];
      tick(int'(VEC[k][15:0]));
      if (VEC[k][16]) begin
        exp_lo += int'(VEC[k][15:0]);
        en_edges += int'(VEC[k][15:0]);
      end
      chk(VEC[k][16] ? "R1 lo step" : "R2 lo hold", {16'h0, lo_count}, 32'(exp_lo));
      chk("R7 combined", combined, 32'(exp_lo));
      chk("R1 R2 prescaled lo", {16'h0, d_lo}, 32'(en_edges / 4));
    end
    lo_en = 1'b1;

    // R8 single clean read: low part is two counts past the request
    rd_req = 1'b1; tick(1); rd_req = 1'b0;
    tick(2);
    chk("R8 not yet valid", {31'h0, snap_valid}, 0);
    tick(1);
    chk("R8 valid", {31'h0, snap_valid}, 1);
    chk("R8 value", snap_value, 32'(exp_lo + 2));
    tick(1);
    chk("R8 pulse ends", {31'h0, snap_valid}, 0);
    chk("R8 value held", snap_value, 32'(exp_lo + 2));

    // R10 request held through the sample gives one result
    rd_req = 1'b1; tick(3); rd_req = 1'b0;
    pulses = 0;
    for (int j = 0; j < 8; j++) begin
      tick(1);
      if (snap_valid) pulses++;
    end
    chk("R10 one pulse", 32'(pulses), 1);

    // R3 wave and R1 no clear at the mid compare
    sync_cmd = 1'b1; tick(1); sync_cmd = 1'b0;
    tick(32768);
    chk("R3 wave at 0x8000", {31'h0, lo_wave}, 1);
    tick(1);
    chk("R3 wave fell", {31'h0, lo_wave}, 0);
    chk("R1 passes 0x8000", {16'h0, lo_count}, 32'h8001);
    tick(32766);
    chk("R1 at top", {16'h0, lo_count}, 32'hFFFF);
    tick(1);
    chk("R1 wrap", {16'h0, lo_count}, 0);
    chk("R3 wave low at wrap", {31'h0, lo_wave}, 0);
    tick(1);
    chk("R3 wave rose", {31'h0, lo_wave}, 1);

    // R4 step timing overlapping an R9 read
    rd_req = 1'b1; tick(1); rd_req = 1'b0;
    tick(1);
    chk("R4 hi not yet", {16'h0, hi_count}, 0);
    tick(1);
    chk("R4 hi stepped", {16'h0, hi_count}, 1);
    chk("R7 combined after step", combined, 32'h0001_0004);
    tick(1);
    chk("R9 torn pass rejected", {31'h0, snap_valid}, 0);
    tick(1);
    chk("R9 still retrying", {31'h0, snap_valid}, 0);
    tick(1);
    chk("R9 valid after retry", {31'h0, snap_valid}, 1);
    chk("R9 consistent value", snap_value, 32'h0001_0005);

    // R5 step lost with hi_en low
    hi_en = 1'b0;
    tick(65529);
    chk("R5 lo wrapped", {16'h0, lo_count}, 0);
    tick(5);
    chk("R5 hi held", {16'h0, hi_count}, 1);
    hi_en = 1'b1;

    // R6 sync overrides enables
    sync_cmd = 1'b1; tick(1); sync_cmd = 1'b0;
    chk("R6 lo cleared", {16'h0, lo_count}, 0);
    chk("R6 hi cleared", {16'h0, hi_count}, 0);
    chk("R6 wave set", {31'h0, lo_wave}, 1);
    chk("R6 prescaled lo cleared", {16'h0, d_lo}, 0);
    tick(4);
    chk("R1 R6 prescaler restarts", {16'h0, d_lo}, 1);

    summary();
    $finish;
  end
endmodule